// File: doc/BRIEF.md
# Sticky Event Interrupt Flag Register

This block collects one-cycle event pulses from several peripherals into one 8-bit register of sticky interrupt request flags. A flag rises in the clock cycle after its event is qualified. It then stays at 1 until software clears it. The peripherals that feed it are a low-power transition controller, an A/D converter, a capture-pin timer, a dual-byte compare timer that can run as two 8-bit halves or as one cascaded 16-bit counter, an 8-bit up/down timer, and an asynchronous event counter.

Software reaches the register through a small synchronous port. The port has an address, a read strobe, a write strobe and write data. The register answers at one address only. Writing a 0 to an event flag clears that flag. Writing a 1 to it leaves it alone. Bit 5 has no event source and works as an ordinary storage bit. The `flags_o` vector is always visible, so downstream enable and priority logic can use it directly.

The design does not fit a state-machine layout well. Each bit is a two-state cell, idle (0) or pending (1), with these transitions:
- idle to pending on a qualified event;
- pending to idle on a write of 0 that arrives without an event in the same cycle;
- otherwise the cell holds its state.

Top module: `irqf_reg`

## Requirements
- R1: After reset, all eight bits of `flags_o` are 0.
- R2: While `rd_en_i` is 1 and `addr_i` equals `REG_ADDR` (default 0xF7), `rdata_o` equals `flags_o`. In every other case `rdata_o` is 0.
- R3: Consider bits 7, 6, 4, 3, 2, 1 and 0. A write hits when `wr_en_i` is 1 and `addr_i` equals `REG_ADDR`. On a hitting write, a 0 in `wdata_i` clears that bit on the next edge, and a 1 leaves it unchanged. A write to any other address changes nothing.
- R4: Bit 5 takes `wdata_i[5]` on every hitting write and otherwise holds its value. No event input changes it.
- R5: Bit 7 is set when `sleep_req_i` is 1 and `dt_en_i` is 1 in the same cycle. A sleep request with `dt_en_i` at 0 does not set it.
- R6: Bit 6 is set when `adc_done_i` is 1 and `adc_busy_i` is 0 in the same cycle.
- R7: Bit 4 is set when `cap_edge_i` is 1 and `cap_pin_sel_i` is 1 in the same cycle.
- R8: Bit 3 depends on `cas_mode_i`. When `cas_mode_i` is 0 (8-bit mode), `hi_match_i` sets it. When `cas_mode_i` is 1 (16-bit mode), it is set only when `hi_match_i` and `lo_match_i` are both 1 in the same cycle.
- R9: Bit 2 is set by `lo_match_i` only while `cas_mode_i` is 0.
- R10: Bit 1 is set by `wrap_up_i` (count 0xFF to 0x00) or by `wrap_dn_i` (count 0x00 to 0xFF).
- R11: Bit 0 is set by `aec_ovf_i`.
- R12: A qualified event in the same cycle as a hitting write of 0 to the same bit leaves that bit at 1.
- R13: An event flag never falls without a hitting write of 0 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register address |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when the register is not read |
| sleep_req_i | input | 1 | Sleep request pulse |
| dt_en_i | input | 1 | Direct-transition enable level |
| adc_done_i | input | 1 | A/D conversion finished pulse |
| adc_busy_i | input | 1 | A/D busy flag |
| cap_pin_sel_i | input | 1 | Capture pin function selected |
| cap_edge_i | input | 1 | Designated capture edge seen |
| cas_mode_i | input | 1 | 1 = cascaded 16-bit compare timer |
| hi_match_i | input | 1 | High-byte compare match |
| lo_match_i | input | 1 | Low-byte compare match |
| wrap_up_i | input | 1 | Up/down timer upward wrap |
| wrap_dn_i | input | 1 | Up/down timer downward wrap |
| aec_ovf_i | input | 1 | Asynchronous event counter overflow |
| flags_o | output | 8 | Current flag register |

## Verification
Each bit's state is visible on `flags_o` one edge after its cause. A wrong set qualifier, a lost clear, or a clear that overrides an event therefore shows on the port in the very next cycle. Because the flags are sticky, a wrong value also stays visible until software writes the register again. The bench compares every bit after every edge, and it compares `rdata_o` before the edge. This catches a decode fault in the same cycle as the faulty access.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    localparam int FLAG_W = 8;
    typedef logic [FLAG_W-1:0] irqf_vec_t;

    // Bit positions are part of the software-visible layout.
    localparam int B_DT   = 7;
    localparam int B_ADC  = 6;
    localparam int B_RW   = 5;
    localparam int B_CAP  = 4;
    localparam int B_HI   = 3;
    localparam int B_LO   = 2;
    localparam int B_WRAP = 1;
    localparam int B_AEC  = 0;

    // Bits that software may only clear.
    localparam irqf_vec_t CLR_ONLY_MASK = irqf_vec_t'(~(FLAG_W'(1) << B_RW));
endpackage

// File: rtl/irqf_set_decode.sv
module irqf_set_decode
    import irqf_pkg::*;
(
    input  logic      sleep_req_i,
    input  logic      dt_en_i,
    input  logic      adc_done_i,
    input  logic      adc_busy_i,
    input  logic      cap_pin_sel_i,
    input  logic      cap_edge_i,
    input  logic      cas_mode_i,
    input  logic      hi_match_i,
    input  logic      lo_match_i,
    input  logic      wrap_up_i,
    input  logic      wrap_dn_i,
    input  logic      aec_ovf_i,
    output irqf_vec_t set_o
);
    always_comb begin
        set_o         = '0;
        set_o[B_DT]   = sleep_req_i & dt_en_i;
        set_o[B_ADC]  = adc_done_i & ~adc_busy_i;
        set_o[B_CAP]  = cap_edge_i & cap_pin_sel_i;
        set_o[B_HI]   = cas_mode_i ? (hi_match_i & lo_match_i) : hi_match_i;
        set_o[B_LO]   = lo_match_i & ~cas_mode_i;
        set_o[B_WRAP] = wrap_up_i | wrap_dn_i;
        set_o[B_AEC]  = aec_ovf_i;
    end
endmodule

// File: rtl/irqf_bit.sv
module irqf_bit #(
    parameter bit CLEAR_ONLY = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic wr_i,
    input  logic wd_i,
    output logic q_o
);
    typedef enum logic {IDLE = 1'b0, PEND = 1'b1} cell_e;
    cell_e state_q, state_d;

    always_comb begin
        logic wr_val;
        wr_val = CLEAR_ONLY ? (wd_i & (state_q == PEND)) : wd_i;
        unique case (state_q)
            IDLE:    state_d = (set_i || (wr_i && wr_val)) ? PEND : IDLE;
            PEND:    state_d = (set_i || !wr_i || wr_val) ? PEND : IDLE;
            default: state_d = IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= IDLE;
        else         state_q <= state_d;
    end

    always_comb q_o = (state_q == PEND);
endmodule

// File: rtl/irqf_reg.sv
module irqf_reg
    import irqf_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'('hF7)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic              sleep_req_i,
    input  logic              dt_en_i,
    input  logic              adc_done_i,
    input  logic              adc_busy_i,
    input  logic              cap_pin_sel_i,
    input  logic              cap_edge_i,
    input  logic              cas_mode_i,
    input  logic              hi_match_i,
    input  logic              lo_match_i,
    input  logic              wrap_up_i,
    input  logic              wrap_dn_i,
    input  logic              aec_ovf_i,
    output logic [7:0]        flags_o
);
    irqf_vec_t set_vec;
    logic      hit, wr_hit;

    always_comb begin
        hit    = (addr_i == REG_ADDR);
        wr_hit = wr_en_i & hit;
    end

    irqf_set_decode u_dec (
        .sleep_req_i  (sleep_req_i),
        .dt_en_i      (dt_en_i),
        .adc_done_i   (adc_done_i),
        .adc_busy_i   (adc_busy_i),
        .cap_pin_sel_i(cap_pin_sel_i),
        .cap_edge_i   (cap_edge_i),
        .cas_mode_i   (cas_mode_i),
        .hi_match_i   (hi_match_i),
        .lo_match_i   (lo_match_i),
        .wrap_up_i    (wrap_up_i),
        .wrap_dn_i    (wrap_dn_i),
        .aec_ovf_i    (aec_ovf_i),
        .set_o        (set_vec)
    );

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        irqf_bit #(.CLEAR_ONLY(CLR_ONLY_MASK[i])) u_bit (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .set_i (set_vec[i]),
            .wr_i  (wr_hit),
            .wd_i  (wdata_i[i]),
            .q_o   (flags_o[i])
        );
    end

    always_comb rdata_o = (rd_en_i && hit) ? flags_o : '0;
endmodule

// File: rtl/irqf_reg_chk.sv
module irqf_reg_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'('hF7)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_en_i,
    input logic              wr_en_i,
    input logic [7:0]        wdata_i,
    input logic [7:0]        rdata_o,
    input logic              sleep_req_i,
    input logic              dt_en_i,
    input logic              cas_mode_i,
    input logic              hi_match_i,
    input logic              lo_match_i,
    input logic              wrap_up_i,
    input logic              aec_ovf_i,
    input logic [7:0]        flags_o
);
    logic wr_hit;
    always_comb wr_hit = wr_en_i && (addr_i == REG_ADDR);

    // R2
    miss_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i != REG_ADDR) |-> rdata_o == 8'h00);
    // R3
    clear_aec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_hit && !wdata_i[0] && !aec_ovf_i) |=> !flags_o[0]);
    // R4
    rw_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_hit |=> flags_o[5] == $past(wdata_i[5]));
    // R5
    dt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sleep_req_i && dt_en_i) |=> flags_o[7]);
    // R8
    hi_cascade_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cas_mode_i && hi_match_i && !lo_match_i && !flags_o[3] && !wr_hit) |=> !flags_o[3]);
    // R9
    lo_cascade_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cas_mode_i && !flags_o[2] && !wr_hit) |=> !flags_o[2]);
    // R12
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_hit && !wdata_i[1] && wrap_up_i) |=> flags_o[1]);
    // R13
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_hit |=> (($past(flags_o) & ~flags_o & 8'hDF) == 8'h00));
endmodule

bind irqf_reg irqf_reg_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .sleep_req_i(sleep_req_i),
    .dt_en_i    (dt_en_i),
    .cas_mode_i (cas_mode_i),
    .hi_match_i (hi_match_i),
    .lo_match_i (lo_match_i),
    .wrap_up_i  (wrap_up_i),
    .aec_ovf_i  (aec_ovf_i),
    .flags_o    (flags_o)
);

// File: tb/irqf_reg_bench.sv
module irqf_reg_bench;
    localparam logic [7:0] RA = 8'hF7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = RA, wdata = 8'hFF;
    logic       rd_en = 0, wr_en = 0;
    logic       sleep_req = 0, dt_en = 0, adc_done = 0, adc_busy = 0;
    logic       cap_sel = 0, cap_edge = 0, cas = 0, hi_m = 0, lo_m = 0;
    logic       w_up = 0, w_dn = 0, ovf = 0;
    logic [7:0] rdata, flags;

    int checks = 0, errors = 0;
    logic [7:0] model = 8'h00;
    string bit_tag [8] = '{"R11", "R10", "R9", "R8", "R7", "R4", "R6", "R5"};

    always #10 clk = ~clk;

    irqf_reg u_irqf_reg (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .wdata_i(wdata), .rdata_o(rdata), .sleep_req_i(sleep_req), .dt_en_i(dt_en),
        .adc_done_i(adc_done), .adc_busy_i(adc_busy), .cap_pin_sel_i(cap_sel),
        .cap_edge_i(cap_edge), .cas_mode_i(cas), .hi_match_i(hi_m), .lo_match_i(lo_m),
        .wrap_up_i(w_up), .wrap_dn_i(w_dn), .aec_ovf_i(ovf), .flags_o(flags)
    );

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] set_of();
        logic [7:0] s = '0;
        s[7] = sleep_req & dt_en;
        s[6] = adc_done & ~adc_busy;
        s[4] = cap_sel & cap_edge;
        s[3] = cas ? (hi_m & lo_m) : hi_m;
        s[2] = lo_m & ~cas;
        s[1] = w_up | w_dn;
        s[0] = ovf;
        return s;
    endfunction

    function automatic logic [7:0] next_of(logic [7:0] cur);
        logic [7:0] n = cur;
        if (wr_en && addr == RA) begin
            n = (cur & wdata & 8'hDF) | (wdata & 8'h20);
        end
        return n | set_of();
    endfunction

    task automatic clear_inputs();
        sleep_req = 0; dt_en = 0; adc_done = 0; adc_busy = 0; cap_sel = 0; cap_edge = 0;
        cas = 0; hi_m = 0; lo_m = 0; w_up = 0; w_dn = 0; ovf = 0;
        wr_en = 0; rd_en = 0; addr = RA; wdata = 8'hFF;
    endtask

    // Inputs already driven at negedge; check read path, advance one edge, check flags.
    task automatic step(string tag);
        #1;
        check("R2", rdata, (rd_en && addr == RA) ? model : 8'h00);
        model = next_of(model);
        @(negedge clk);
        for (int b = 0; b < 8; b++) check(bit_tag[b], {7'd0, flags[b]}, {7'd0, model[b]});
        if (tag != "") check(tag, flags, model);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", flags, 8'h00);
        rst_n = 1;
        @(negedge clk);
        check("R1", flags, 8'h00);

        // R5: sleep without enable, then with enable
        sleep_req = 1; step("R5"); sleep_req = 0;
        dt_en = 1; sleep_req = 1; step("R5"); clear_inputs();
        // R6: done while busy, then idle
        adc_done = 1; adc_busy = 1; step("R6"); adc_busy = 0; step("R6"); clear_inputs();
        // R7
        cap_edge = 1; step("R7"); cap_sel = 1; step("R7"); clear_inputs();
        // R8/R9: cascaded mode, single matches do nothing
        cas = 1; hi_m = 1; step("R8"); hi_m = 0; lo_m = 1; step("R9");
        hi_m = 1; step("R8"); clear_inputs();
        lo_m = 1; step("R9"); clear_inputs();
        // R10/R11
        w_dn = 1; step("R10"); clear_inputs(); ovf = 1; step("R11"); clear_inputs();
        // R2: read hit and miss
        rd_en = 1; step("R2"); addr = 8'hF6; step("R2"); clear_inputs();
        // R3: write to wrong address, write ones, then write zeros
        wr_en = 1; addr = 8'hF6; wdata = 8'h00; step("R3");
        addr = RA; wdata = 8'hFF; step("R3");
        // R12: clear with simultaneous wrap
        wdata = 8'h00; w_up = 1; step("R12"); clear_inputs();
        // R4: bit 5 written low, events do not touch it
        wr_en = 1; wdata = 8'h00; step("R4"); clear_inputs();
        sleep_req = 1; dt_en = 1; adc_done = 1; cap_sel = 1; cap_edge = 1; hi_m = 1;
        lo_m = 1; w_up = 1; ovf = 1; step("R4"); clear_inputs();
        // R13: idle cycles hold
        step("R13"); step("R13");

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            sleep_req = ($urandom_range(7) == 0); dt_en = $urandom_range(1);
            adc_done = ($urandom_range(7) == 0); adc_busy = $urandom_range(1);
            cap_sel = $urandom_range(1); cap_edge = ($urandom_range(7) == 0);
            cas = $urandom_range(1); hi_m = ($urandom_range(5) == 0);
            lo_m = ($urandom_range(5) == 0); w_up = ($urandom_range(11) == 0);
            w_dn = ($urandom_range(11) == 0); ovf = ($urandom_range(9) == 0);
            wr_en = ($urandom_range(3) == 0); rd_en = $urandom_range(1);
            addr = ($urandom_range(7) == 0) ? 8'($urandom) : RA;
            wdata = 8'($urandom | $urandom);
            step(wr_en ? "R13" : "");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule